// File: doc/BRIEF.md
# Low-Voltage Reset Filter Controller

This block is the digital half of a supply-voltage supervisor. Two comparators, already synchronous to the clock, report the supply level. One shows that the supply has sagged to or below the falling trip point. The other shows that it sits above a separate, higher rising trip point. The controller screens out short dips by demanding an unbroken run of low samples before it asks for a system reset. It then holds that request until a single sample above the rising point arrives. While the request is held, it also pulls an active-low reset pin down.

Software can watch the supply without any reset risk. An unfiltered status flag mirrors the low comparator whenever monitoring is active. Three static configuration bits, all active low, select the following:
- whether the monitor is powered;
- whether it may raise resets;
- whether it keeps running during stop mode.

A one-cycle cause pulse marks the cycle in which a low-voltage reset begins, so that a reset-cause register elsewhere can latch it.

The control core is a three-state machine:
- **LV_OFF**: monitoring is inactive.
- **LV_WATCH**: monitoring, with no reset pending. This is the state out of reset.
- **LV_TRIP**: a reset is being requested.

Its transitions are:
- **wake**: LV_OFF to LV_WATCH, when monitoring becomes active.
- **sleep**: LV_WATCH or LV_TRIP to LV_OFF, when monitoring becomes inactive.
- **trip**: LV_WATCH to LV_TRIP, on the ninth consecutive low sample with resets enabled.
- **release**: LV_TRIP to LV_WATCH, on one sample above the rising point, or when resets are disabled.

Top module: `lvr_filter_ctrl`

## Requirements
- R1: When monitoring is active and resets are enabled, `rst_req_o` rises after the clock edge that samples `sup_low_i`=1 for the ninth consecutive time.
- R2: A sample with `sup_low_i`=0 restarts the run count. Eight consecutive low samples never raise a reset. A run longer than nine behaves like a run of nine, because the count saturates.
- R3: Once raised, `rst_req_o` stays high while `sup_ok_i`=0, even after `sup_low_i` returns to 0. It falls after the first edge that samples `sup_ok_i`=1.
- R4: With `cfg_pwr_n_i`=1 the monitor is inactive. The run count clears, `rst_req_o` drops after the next edge (even mid-reset), and `low_flag_o` reads 0.
- R5: With `cfg_rst_n_i`=1 (resets disabled) and the monitor powered, no reset is raised for any run length, and `low_flag_o` still tracks the comparator.
- R6: When `stop_i`=1, the monitor is inactive if `cfg_stop_keep_n_i`=1, and keeps working normally if `cfg_stop_keep_n_i`=0.
- R7: `low_flag_o` equals `sup_low_i` in the same cycle, without filtering, whenever monitoring is active.
- R8: During and after `rst_n` reset the controller is in the monitoring state with the count at zero and `rst_req_o`=0, `rst_pin_n_o`=1 and `trip_pulse_o`=0. A run counts from the first cycle after reset.
- R9: `rst_pin_n_o` is the inverse of `rst_req_o`, so the pin is driven low for exactly the cycles in which a low-voltage reset is requested.
- R10: `trip_pulse_o` is high for exactly the one cycle in which `rst_req_o` first reads 1 for a given reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_low_i | input | 1 | Comparator: supply at or below the falling trip point |
| sup_ok_i | input | 1 | Comparator: supply above the rising trip point |
| cfg_pwr_n_i | input | 1 | Monitor power, 0 = powered |
| cfg_rst_n_i | input | 1 | Reset generation, 0 = enabled |
| cfg_stop_keep_n_i | input | 1 | Keep monitoring in stop mode, 0 = keep |
| stop_i | input | 1 | System is in stop mode |
| rst_req_o | output | 1 | Low-voltage reset request |
| rst_pin_n_o | output | 1 | Reset pin drive, active low |
| low_flag_o | output | 1 | Unfiltered low-supply status for polling |
| trip_pulse_o | output | 1 | One-cycle marker of a new low-voltage reset |

## Verification
A run count that is off by one shows at the ports as a reset raised one edge early or late relative to the ninth low sample. Runs of exactly eight and nine, and broken runs, expose such a count within a dozen cycles. A state register stuck in LV_TRIP shows as `rst_req_o` staying high on the cycle after a rising-point sample. A missed sleep transition shows as a reset request that survives a power-off or a stop without the keep bit. Each of these appears at the next sampling edge and is compared against an independent cycle model.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

    typedef enum logic [1:0] {
        LV_OFF   = 2'd0,
        LV_WATCH = 2'd1,
        LV_TRIP  = 2'd2
    } lv_state_e;

endpackage

// File: rtl/lvr_gate.sv
// Decides whether monitoring is live and qualifies the comparator input.
module lvr_gate (
    input  logic pwr_n_i,
    input  logic stop_i,
    input  logic stop_keep_n_i,
    input  logic sup_low_i,
    output logic active_o,
    output logic low_hit_o
);

    logic stop_blocks;

    always_comb begin
        stop_blocks = stop_i && stop_keep_n_i;
        active_o    = !pwr_n_i && !stop_blocks;
        low_hit_o   = active_o && sup_low_i;
    end

endmodule

// File: rtl/lvr_run_counter.sv
// Counts consecutive qualified low samples, saturating at RUN_LEN.
module lvr_run_counter #(
    parameter int RUN_LEN = 9,
    localparam int CW = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    output logic [CW-1:0] cnt_o
);

    localparam logic [CW-1:0] CAP = CW'(RUN_LEN);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!hit_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CAP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    // R2
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CAP);

    // R2
    cnt_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> (cnt_q == '0));

endmodule

// File: rtl/lvr_fsm.sv
// State machine: off / watching / tripped, with cause pulse.
module lvr_fsm
    import lvr_pkg::*;
#(
    parameter int RUN_LEN = 9,
    localparam int CW = $clog2(RUN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic          rst_en_i,
    input  logic          low_i,
    input  logic          ok_i,
    input  logic [CW-1:0] cnt_i,
    output logic          req_o,
    output logic          pulse_o
);

    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    lv_state_e state_q, state_d;
    logic      pulse_q;
    logic      run_done;

    always_comb begin
        run_done = rst_en_i && low_i && (cnt_i >= LAST);
        state_d  = state_q;
        unique case (state_q)
            LV_OFF: begin
                if (active_i) state_d = LV_WATCH;          // wake
            end
            LV_WATCH: begin
                if (!active_i)     state_d = LV_OFF;       // sleep
                else if (run_done) state_d = LV_TRIP;      // trip
            end
            LV_TRIP: begin
                if (!active_i)               state_d = LV_OFF;   // sleep
                else if (ok_i || !rst_en_i)  state_d = LV_WATCH; // release
            end
            default: state_d = LV_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_WATCH;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= (state_d == LV_TRIP) && (state_q != LV_TRIP);
        end
    end

    always_comb begin
        req_o   = (state_q == LV_TRIP);
        pulse_o = pulse_q;
    end

    // R1
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_o) |-> ($past(cnt_i) >= LAST));

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && active_i && ok_i) |=> !req_o);

    // R4
    sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !req_o);

    // R5
    noen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_en_i |=> !req_o);

    // R10
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $rose(req_o));

endmodule

// File: rtl/lvr_filter_ctrl.sv
module lvr_filter_ctrl #(
    parameter int RUN_LEN = 9,
    localparam int CW = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_low_i,
    input  logic sup_ok_i,
    input  logic cfg_pwr_n_i,
    input  logic cfg_rst_n_i,
    input  logic cfg_stop_keep_n_i,
    input  logic stop_i,
    output logic rst_req_o,
    output logic rst_pin_n_o,
    output logic low_flag_o,
    output logic trip_pulse_o
);

    logic          active;
    logic          low_hit;
    logic [CW-1:0] run_cnt;
    logic          req;

    lvr_gate u_gate (
        .pwr_n_i       (cfg_pwr_n_i),
        .stop_i        (stop_i),
        .stop_keep_n_i (cfg_stop_keep_n_i),
        .sup_low_i     (sup_low_i),
        .active_o      (active),
        .low_hit_o     (low_hit)
    );

    lvr_run_counter #(.RUN_LEN(RUN_LEN)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (low_hit),
        .cnt_o (run_cnt)
    );

    lvr_fsm #(.RUN_LEN(RUN_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active),
        .rst_en_i (!cfg_rst_n_i),
        .low_i    (low_hit),
        .ok_i     (sup_ok_i),
        .cnt_i    (run_cnt),
        .req_o    (req),
        .pulse_o  (trip_pulse_o)
    );

    always_comb begin
        rst_req_o   = req;
        rst_pin_n_o = !req;
        low_flag_o  = low_hit;
    end

    // R7
    flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pwr_n_i && !stop_i) |-> (low_flag_o == sup_low_i));

endmodule

// File: tb/lvr_filter_ctrl_test.sv
module lvr_filter_ctrl_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic sup_low, sup_ok, pwr_n, rdis_n, keep_n, stop;
    logic c_pwr_n, c_rdis_n, c_keep_n, c_stop;
    logic rst_req, rst_pin_n, low_flag, trip_pulse;

    lvr_filter_ctrl uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .sup_low_i         (sup_low),
        .sup_ok_i          (sup_ok),
        .cfg_pwr_n_i       (pwr_n),
        .cfg_rst_n_i       (rdis_n),
        .cfg_stop_keep_n_i (keep_n),
        .stop_i            (stop),
        .rst_req_o         (rst_req),
        .rst_pin_n_o       (rst_pin_n),
        .low_flag_o        (low_flag),
        .trip_pulse_o      (trip_pulse)
    );

    typedef struct {
        logic  req;
        logic  pin;
        logic  pulse;
        logic  flag;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;
    int   mcnt   = 0;
    logic mreq   = 1'b0;

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic lo, input logic ok, input string tag);
        logic act, en, nreq;
        exp_t e;
        @(negedge clk);
        #1;
        sup_low = lo;  sup_ok = ok;
        pwr_n = c_pwr_n; rdis_n = c_rdis_n; keep_n = c_keep_n; stop = c_stop;
        act = !c_pwr_n && !(c_stop && c_keep_n);
        en  = !c_rdis_n;
        if (!act) begin
            nreq = 1'b0;
            mcnt = 0;
        end else begin
            if (mreq) nreq = en && !ok;
            else      nreq = en && lo && (mcnt >= 8);
            mcnt = lo ? ((mcnt < 9) ? mcnt + 1 : 9) : 0;
        end
        e.req   = nreq;
        e.pin   = !nreq;
        e.pulse = nreq && !mreq;
        e.flag  = act && lo;
        e.tag   = tag;
        mreq    = nreq;
        sb.push_back(e);
    endtask

    task automatic run(input int n, input logic lo, input logic ok, input string tag);
        for (int i = 0; i < n; i++) step(lo, ok, tag);
    endtask

    // Monitor: compare one expected item per cycle, away from the active edge.
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (rst_req !== e.req || rst_pin_n !== e.pin ||
                trip_pulse !== e.pulse || low_flag !== e.flag) begin
                errors++;
                $display("FAIL %s req=%b pin=%b pulse=%b flag=%b expected req=%b pin=%b pulse=%b flag=%b",
                         e.tag, rst_req, rst_pin_n, trip_pulse, low_flag,
                         e.req, e.pin, e.pulse, e.flag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        sup_low = 1'b0; sup_ok = 1'b1;
        c_pwr_n = 1'b0; c_rdis_n = 1'b0; c_keep_n = 1'b1; c_stop = 1'b0;
        pwr_n = c_pwr_n; rdis_n = c_rdis_n; keep_n = c_keep_n; stop = c_stop;
        repeat (3) @(negedge clk);
        checks++;   // R8 reset state
        if (rst_req !== 1'b0 || rst_pin_n !== 1'b1 || trip_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset req=%b pin=%b pulse=%b expected req=0 pin=1 pulse=0",
                     rst_req, rst_pin_n, trip_pulse);
        end
        #1 rst_n = 1'b1;

        run(3, 1'b0, 1'b1, "R8 idle after reset");
        // R2: eight low samples do not trip; broken runs restart
        run(8, 1'b1, 1'b0, "R2 eight low");
        run(1, 1'b0, 1'b1, "R2 break");
        run(3, 1'b1, 1'b0, "R2 short run");
        run(1, 1'b0, 1'b0, "R2 break mid");
        run(8, 1'b1, 1'b0, "R2 restarted run");
        run(1, 1'b0, 1'b1, "R2 break");
        // R1 / R9 / R10: nine low samples trip
        run(9, 1'b1, 1'b0, "R1 nine low");
        run(3, 1'b1, 1'b0, "R10 held no repeat pulse");
        // R3: held until above rising point, then one cycle releases
        run(2, 1'b0, 1'b0, "R3 between thresholds");
        run(1, 1'b0, 1'b1, "R3 release");
        run(2, 1'b0, 1'b1, "R3 idle");
        // R2 saturation: long run behaves as nine
        run(15, 1'b1, 1'b0, "R2 saturated run");
        run(1, 1'b0, 1'b1, "R3 release after long run");
        // R7 flag unfiltered
        run(1, 1'b1, 1'b0, "R7 flag single");
        run(1, 1'b0, 1'b1, "R7 flag clear");
        // R5 resets disabled
        c_rdis_n = 1'b1;
        run(12, 1'b1, 1'b0, "R5 poll only");
        run(1, 1'b0, 1'b1, "R5 poll clear");
        c_rdis_n = 1'b0;
        // R4 power off
        c_pwr_n = 1'b1;
        run(12, 1'b1, 1'b0, "R4 unpowered");
        c_pwr_n = 1'b0;
        run(1, 1'b0, 1'b1, "R4 repowered");
        run(10, 1'b1, 1'b0, "R4 trip before power off");
        c_pwr_n = 1'b1;
        run(2, 1'b1, 1'b0, "R4 power off mid reset");
        c_pwr_n = 1'b0;
        run(1, 1'b0, 1'b1, "R4 repowered");
        // R6 stop mode
        c_stop = 1'b1; c_keep_n = 1'b1;
        run(12, 1'b1, 1'b0, "R6 stop halts monitor");
        c_keep_n = 1'b0;
        run(9, 1'b1, 1'b0, "R6 stop keep trips");
        run(1, 1'b0, 1'b1, "R6 stop keep release");
        c_stop = 1'b0; c_keep_n = 1'b1;
        run(2, 1'b0, 1'b1, "R9 idle pin high");

        repeat (3) @(negedge clk);
        #2;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule